// File: doc/BRIEF.md
# Sparse Parallel-Prefix Adder

This block adds two unsigned operands and a carry-in in a single combinational pass and returns the sum together with a carry-out. Each bit first forms a generate term (both operand bits set) and a propagate term (operand bits differ). A log-depth network of prefix cells then merges these terms into group carries, where each cell folds a lower span into the span above it. The carry-in enters that network as an extra position below bit 0 with propagate held low, so every span that reaches down to the bottom already includes it.

A build-time switch picks how dense the carry network is. In dense mode, every bit position gets its carry from the network. In sparse mode, the network produces carries only at even positions (bit 0, 2, 4, ...). Each odd bit then forms two candidate sums, one per possible value of the carry into the even bit below it, and that even carry picks the right one. Both modes give exactly the arithmetic sum. The adder has no clock and no handshake: it is a datapath element that sits between registers owned by its user, so the outputs follow the inputs within the same cycle.

Top module: `sprefix_adder`

## Requirements
- R1: With SPARSE=0, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a W+1 bit unsigned sum, for every input combination.
- R2: With SPARSE=1, {cout_o, sum_o} equals a_i + b_i + cin_i taken as a W+1 bit unsigned sum, for every input combination.
- R3: With both operands zero, sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o is 0.
- R4: When b_i is the bitwise inverse of a_i, every bit propagates. With cin_i=0 the sum is all ones and cout_o=0. With cin_i=1 the sum is all zeros and cout_o=1.
- R5: sum_o bit 0 equals a_i[0] XOR b_i[0] XOR cin_i.
- R6: When the top bit of both operands is 1, cout_o is 1 whatever the other bits are.
- R7: In sparse mode, a carry generated at an even bit reaches the odd bit above it. For example, 0x5555 + 0x5555 gives 0xAAAA with carry-out 0, and 0x0001 + 0x0001 + 1 gives 0x0003.
- R8: Both modes return identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, unsigned |
| b_i | input | W | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Low W bits of the sum |
| cout_o | output | 1 | Carry out of bit W-1 |

## Verification
The bound checker compares the outputs against the arithmetic sum on every input change. On the same events it checks the bit-0 sum, the all-zero operand case, the all-propagate ripple case and the forced carry-out from the top bits. The checker cannot show which path produced a given odd-position carry in sparse mode. Only the bench's chosen operands can show that, because they make carries start at even bits and travel the full width of the adder. The bench also drives the two modes side by side to show that they agree.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } span_t;

  function automatic span_t merge_span(input span_t hi, input span_t lo);
    span_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction
endpackage

// File: rtl/spa_bit_terms.sv
module spa_bit_terms #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/spa_prefix_cell.sv
module spa_prefix_cell
  import spa_pkg::*;
(
  input  logic hi_g,
  input  logic hi_p,
  input  logic lo_g,
  input  logic lo_p,
  output logic grp_g,
  output logic grp_p
);
  span_t r;
  always_comb r = merge_span('{g: hi_g, p: hi_p}, '{g: lo_g, p: lo_p});
  assign grp_g = r.g;
  assign grp_p = r.p;
endmodule

// File: rtl/spa_carry_tree.sv
module spa_carry_tree #(
  parameter int W      = 16,
  parameter bit SPARSE = 1'b1
) (
  input  logic [W-2:0] gen_i,
  input  logic [W-2:0] prop_i,
  input  logic         cin_i,
  output logic [W-1:0] carry_o
);
  localparam int LVLS = $clog2(W);

  // Position j holds the span ending at bit j-1; position 0 is the carry-in.
  logic [LVLS:0][W-1:0] gl;
  logic [LVLS:0][W-1:0] pl;

  assign gl[0][0] = cin_i;
  assign pl[0][0] = 1'b0;
  assign gl[0][W-1:1] = gen_i;
  assign pl[0][W-1:1] = prop_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar j = 0; j < W; j++) begin : g_pos
      if (j >= D && (!SPARSE || (j % 2) == 0)) begin : g_cell
        spa_prefix_cell u_cell (
          .hi_g (gl[l][j]),
          .hi_p (pl[l][j]),
          .lo_g (gl[l][j-D]),
          .lo_p (pl[l][j-D]),
          .grp_g(gl[l+1][j]),
          .grp_p(pl[l+1][j])
        );
      end else begin : g_pass
        assign gl[l+1][j] = gl[l][j];
        assign pl[l+1][j] = pl[l][j];
      end
    end
  end

  assign carry_o = gl[LVLS];

  logic unused_top_p;
  assign unused_top_p = ^pl[LVLS];
endmodule

// File: rtl/spa_sum_stage.sv
module spa_sum_stage #(
  parameter int W      = 16,
  parameter bit SPARSE = 1'b1
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] carry_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] cin_bit;

  for (genvar i = 0; i < W; i++) begin : g_sum
    if (!SPARSE || (i % 2) == 0) begin : g_tree
      assign cin_bit[i] = carry_i[i];
    end else begin : g_select
      logic c_if0, c_if1;
      assign c_if0 = gen_i[i-1];
      assign c_if1 = gen_i[i-1] | prop_i[i-1];
      logic s_if0, s_if1;
      assign s_if0 = prop_i[i] ^ c_if0;
      assign s_if1 = prop_i[i] ^ c_if1;
      assign cin_bit[i] = carry_i[i-1] ? c_if1 : c_if0;
      logic sel_sum;
      assign sel_sum = carry_i[i-1] ? s_if1 : s_if0;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_out
    if (!SPARSE || (i % 2) == 0) begin : g_plain
      assign sum_o[i] = prop_i[i] ^ cin_bit[i];
    end else begin : g_pick
      assign sum_o[i] = g_sum[i].g_select.sel_sum;
    end
  end

  assign cout_o = gen_i[W-1] | (prop_i[W-1] & cin_bit[W-1]);

  logic unused_skipped;
  if (SPARSE) begin : g_unused_sp
    logic [W/2-1:0] odd_c;
    for (genvar k = 0; k < W/2; k++) begin : g_odd
      assign odd_c[k] = carry_i[2*k+1];
    end
    assign unused_skipped = ^odd_c;
  end else begin : g_unused_full
    assign unused_skipped = 1'b0;
  end
endmodule

// File: rtl/sprefix_adder.sv
module sprefix_adder #(
  parameter int W      = 16,
  parameter bit SPARSE = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] gen_w;
  logic [W-1:0] prop_w;
  logic [W-1:0] carry_w;

  spa_bit_terms #(.W(W)) u_terms (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (gen_w),
    .prop_o(prop_w)
  );

  spa_carry_tree #(.W(W), .SPARSE(SPARSE)) u_tree (
    .gen_i  (gen_w[W-2:0]),
    .prop_i (prop_w[W-2:0]),
    .cin_i  (cin_i),
    .carry_o(carry_w)
  );

  spa_sum_stage #(.W(W), .SPARSE(SPARSE)) u_sum (
    .gen_i  (gen_w),
    .prop_i (prop_w),
    .carry_i(carry_w),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );
endmodule

// File: rtl/sprefix_adder_chk.sv
module sprefix_adder_chk #(
  parameter int W      = 16,
  parameter bit SPARSE = 1'b1
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o
);
  logic [W:0] ref_sum;
  always_comb ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  if (SPARSE) begin : g_sparse
    always_comb begin
      p_sum_sparse_r2: assert ({cout_o, sum_o} == ref_sum);
    end
  end else begin : g_full
    always_comb begin
      p_sum_full_r1: assert ({cout_o, sum_o} == ref_sum);
    end
  end

  always_comb begin
    p_zero_ops_r3: assert (!(a_i == '0 && b_i == '0) ||
                           (sum_o == {{(W-1){1'b0}}, cin_i} && !cout_o));
    p_prop_chain_r4: assert (!(b_i == ~a_i) ||
                             (sum_o == {W{~cin_i}} && cout_o == cin_i));
    p_lsb_sum_r5: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i));
    p_top_gen_r6: assert (!(a_i[W-1] && b_i[W-1]) || cout_o);
  end
endmodule

bind sprefix_adder sprefix_adder_chk #(.W(W), .SPARSE(SPARSE)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/test_sprefix_adder.sv
module test_sprefix_adder;
  localparam int W = 16;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum_sp, sum_fu;
  logic         cout_sp, cout_fu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  sprefix_adder #(.W(W), .SPARSE(1'b1)) i_sprefix_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_sp), .cout_o(cout_sp)
  );
  sprefix_adder #(.W(W), .SPARSE(1'b0)) i_sprefix_adder_full (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_fu), .cout_o(cout_fu)
  );

  // {a, b, cin}
  localparam logic [2*W:0] VEC [0:NVEC-1] = '{
    {16'h0001, 16'h0001, 1'b0},
    {16'h1234, 16'h4321, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0},
    {16'h7FFF, 16'h7FFF, 1'b1},
    {16'hAAAA, 16'h5556, 1'b0},
    {16'h00FF, 16'hFF01, 1'b1},
    {16'h8001, 16'h7FFF, 1'b0},
    {16'hC3A5, 16'h5A3C, 1'b1},
    {16'h0F0F, 16'h0F0F, 1'b1},
    {16'hFFFE, 16'h0001, 1'b1},
    {16'h2AAA, 16'h2AAA, 1'b0},
    {16'h9999, 16'h6667, 1'b0}
  };

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  task automatic both_modes(input logic [W:0] exp);
    check("R1", {cout_fu, sum_fu}, exp);
    check("R2", {cout_sp, sum_sp}, exp);
    check("R8", {cout_sp, sum_sp}, {cout_fu, sum_fu});
  endtask

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    // All-zero idle inputs
    check("R3", {cout_sp, sum_sp}, '0);
    check("R3", {cout_fu, sum_fu}, '0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
      both_modes(ref_add(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]));
    end

    // Pseudo-random sweep
    begin
      logic [31:0] s = 32'h1ACE_B00C;
      for (int i = 0; i < 300; i++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        apply(s[15:0], s[31:16], s[7]);
        both_modes(ref_add(s[15:0], s[31:16], s[7]));
      end
    end

    // R3: carry-in alone
    apply('0, '0, 1'b1);
    check("R3", {cout_sp, sum_sp}, 17'h00001);
    check("R3", {cout_fu, sum_fu}, 17'h00001);

    // R4: all-propagate
    apply(16'hA5C3, 16'h5A3C, 1'b0);
    check("R4", {cout_sp, sum_sp}, 17'h0FFFF);
    check("R4", {cout_fu, sum_fu}, 17'h0FFFF);
    apply(16'hA5C3, 16'h5A3C, 1'b1);
    check("R4", {cout_sp, sum_sp}, 17'h10000);
    check("R4", {cout_fu, sum_fu}, 17'h10000);

    // R5: bit 0 sum
    apply(16'h0001, 16'h0000, 1'b1);
    check("R5", {16'h0, sum_sp[0]}, 17'h0);
    check("R5", {16'h0, sum_fu[0]}, 17'h0);

    // R6: top bits both set
    apply(16'h8000, 16'h8000, 1'b0);
    check("R6", {cout_sp, sum_sp}, 17'h10000);
    check("R6", {cout_fu, sum_fu}, 17'h10000);

    // R7: even-generated carries into odd bits, sparse mode
    apply(16'h5555, 16'h5555, 1'b0);
    check("R7", {cout_sp, sum_sp}, 17'h0AAAA);
    apply(16'h0001, 16'h0001, 1'b1);
    check("R7", {cout_sp, sum_sp}, 17'h00003);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R7", {cout_sp, sum_sp}, 17'h1FFFF);
    check("R8", {cout_sp, sum_sp}, {cout_fu, sum_fu});

    finish_run();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end
endmodule